// File: doc/BRIEF.md
# Storage Controller Doorbell and Interrupt Register Bank

This block is the device-side register window through which a host signals a storage controller. It decodes a simple single-cycle write port and a combinational read port into a window of 0x600 bytes. The window holds an inbound doorbell, an outbound doorbell, an interrupt mask and an error status word, a 64-bit command mailbox address and a command completion word. Most registers can be reached at two addresses. Ones written at the set address raise bits and ones written at the clear address lower them. On several registers the bits the host writes mean something different from the bits it reads back.

The controller side drives pulse inputs. These post hardware-mailbox and memory-mailbox completions, consume a hardware-mailbox command and post an error with two parameter bytes. In return the controller side sees the mailbox-full level, one-cycle strobes for doorbell commands, the mailbox address and the initialization-busy flag. The interrupt output is high while a status-available bit is pending and its mask bit is clear.

A controller-reset doorbell starts a small sequencer with two states. ST_INIT counts down for INIT_CYCLES cycles while the initialization-in-progress bit reads as one. The transition INIT_DONE moves it to ST_READY when the count reaches zero. The transition RESTART returns it to ST_INIT from either state on a controller-reset write. Power-on reset also enters ST_INIT.

Top module: `doorbell_regbank`

## Requirements
- R1: Writes to addresses with no register, or at or above 0x600, change nothing, and such addresses read zero. Bits with no defined meaning read zero. A write of all zeros to any set or clear address has no effect.
- R2: Writing bit 24 at 0x214 sets the mailbox-full flag, which reads at 0x214 bit 24 and drives `hmb_full`. A `dev_hmb_consume` pulse clears the flag. When both happen in the same cycle, the flag is set.
- R3: Bit 26 at 0x214 raises `gen_int_pulse` and bit 28 at 0x214 raises `mmb_new_pulse`. Bit 25 at 0x218 raises `hmb_ack_pulse`. Each strobe is high for exactly the one cycle after the write.
- R4: Writing bit 27 at 0x214 clears the mailbox-full flag, both status-available bits and any pending error, and leaves the mask unchanged. The initialization-in-progress bit (0x214 bit 25, also `init_busy`) then reads one for exactly INIT_CYCLES cycles. It does the same after power-on reset.
- R5: `dev_hmb_status_set` sets outbound bit 24 and `dev_mmb_status_set` sets outbound bit 25. Both read at 0x224 and are cleared by writing ones at 0x228. A set in the same cycle as a clear leaves the bit set.
- R6: The mask resets to 0x03000000. Ones at 0x22C set mask bits 24 and 25, and ones at 0x230 clear them. The mask reads at 0x22C, and 0x230 reads zero.
- R7: 0x208 reads the outbound bits 24 and 25 ANDed with the inverted mask. `irq` is high while any of those bits is one, and it is low in the cycle after the acknowledging write.
- R8: Writes at 0x510 and 0x514 load the low and high halves of `mbox_addr`.
- R9: A `dev_hmb_status_set` pulse captures `dev_cmd_id` into bits 15:0 and `dev_cmd_status` into bits 31:16 of the word at 0x518.
- R10: A `dev_err_post` pulse sets bit 29 at 0x224 and puts the error code in bits 7:0 at 0x224. Parameter byte 0 reads at 0x510 bits 7:0 and parameter byte 1 at bits 15:8. A write at 0x228 with bits 24 and 25 both set retires the error and zeroes these fields. A write with only one of those bits set leaves the error pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| addr | input | ADDR_W | Byte address within the window |
| wdata | input | 32 | Host write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| dev_hmb_consume | input | 1 | Controller took the hardware-mailbox command |
| dev_hmb_status_set | input | 1 | Post hardware-mailbox completion |
| dev_mmb_status_set | input | 1 | Post memory-mailbox completion |
| dev_cmd_id | input | 16 | Command identifier captured with the completion |
| dev_cmd_status | input | 16 | Command status captured with the completion |
| dev_err_post | input | 1 | Post an error |
| dev_err_code | input | 8 | Error code |
| dev_err_p0 | input | 8 | Error parameter byte 0 |
| dev_err_p1 | input | 8 | Error parameter byte 1 |
| hmb_full | output | 1 | Hardware mailbox holds a new command |
| hmb_ack_pulse | output | 1 | Host acknowledged hardware-mailbox status |
| gen_int_pulse | output | 1 | Host asked the controller to raise an interrupt |
| mmb_new_pulse | output | 1 | Host queued a memory-mailbox command |
| init_busy | output | 1 | Initialization in progress |
| mbox_addr | output | 64 | Command mailbox bus address |
| irq | output | 1 | Interrupt to the host |

## Verification
The bench targets cycles in which a controller event and a host clear hit the same bit. A design that gave the host priority would drop a completion or a mailbox command, and that bit would read zero afterwards. It checks that the error retires only on the two-bit clear pattern. A design that retired on either bit would lose an error when the host acknowledges a single status bit. It counts the busy window after power-on and after a controller-reset doorbell, which exposes off-by-one counters. It also writes to aliased out-of-window addresses and writes zero or undefined-only data, which catches a decoder that drops the upper address bits or treats the data as a plain store.

// File: rtl/dbrb_pkg.sv
`timescale 1ns/1ps
package dbrb_pkg;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned WIN_BYTES = 'h600;

    // Register offsets
    localparam int unsigned OFF_IRQ_STAT = 'h208;
    localparam int unsigned OFF_IB_SET   = 'h214;
    localparam int unsigned OFF_IB_CLR   = 'h218;
    localparam int unsigned OFF_OB_SET   = 'h224;
    localparam int unsigned OFF_OB_CLR   = 'h228;
    localparam int unsigned OFF_MSK_SET  = 'h22C;
    localparam int unsigned OFF_MSK_CLR  = 'h230;
    localparam int unsigned OFF_MB_LO    = 'h510;
    localparam int unsigned OFF_MB_HI    = 'h514;
    localparam int unsigned OFF_CMD      = 'h518;

    // Bit positions
    localparam int unsigned B_LO   = 24;  // hardware mailbox: full / new / status
    localparam int unsigned B_HI   = 25;  // ack, init busy, memory mailbox status
    localparam int unsigned B_GEN  = 26;
    localparam int unsigned B_RST  = 27;
    localparam int unsigned B_MMB  = 28;
    localparam int unsigned B_ERR  = 29;

    typedef enum logic [0:0] {
        ST_INIT  = 1'b0,
        ST_READY = 1'b1
    } init_state_e;

    typedef enum logic [2:0] {
        RS_NONE, RS_IRQ_STAT, RS_IB, RS_OB, RS_MSK, RS_MB_LO, RS_CMD
    } rd_sel_e;

    typedef struct packed {
        logic ib_set;
        logic ib_clr;
        logic ob_clr;
        logic msk_set;
        logic msk_clr;
        logic mb_lo;
        logic mb_hi;
    } wr_sel_t;
endpackage

// File: rtl/dbrb_decode.sv
`timescale 1ns/1ps
module dbrb_decode
    import dbrb_pkg::*;
#(
    parameter int unsigned ADDR_W = 11
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output wr_sel_t           wsel,
    output rd_sel_e           rsel
);
    localparam logic [ADDR_W-1:0] A_IRQ_STAT = ADDR_W'(OFF_IRQ_STAT);
    localparam logic [ADDR_W-1:0] A_IB_SET   = ADDR_W'(OFF_IB_SET);
    localparam logic [ADDR_W-1:0] A_IB_CLR   = ADDR_W'(OFF_IB_CLR);
    localparam logic [ADDR_W-1:0] A_OB_SET   = ADDR_W'(OFF_OB_SET);
    localparam logic [ADDR_W-1:0] A_OB_CLR   = ADDR_W'(OFF_OB_CLR);
    localparam logic [ADDR_W-1:0] A_MSK_SET  = ADDR_W'(OFF_MSK_SET);
    localparam logic [ADDR_W-1:0] A_MSK_CLR  = ADDR_W'(OFF_MSK_CLR);
    localparam logic [ADDR_W-1:0] A_MB_LO    = ADDR_W'(OFF_MB_LO);
    localparam logic [ADDR_W-1:0] A_MB_HI    = ADDR_W'(OFF_MB_HI);
    localparam logic [ADDR_W-1:0] A_CMD      = ADDR_W'(OFF_CMD);

    always_comb begin
        wsel         = '0;
        wsel.ib_set  = wr_en && (addr == A_IB_SET);
        wsel.ib_clr  = wr_en && (addr == A_IB_CLR);
        wsel.ob_clr  = wr_en && (addr == A_OB_CLR);
        wsel.msk_set = wr_en && (addr == A_MSK_SET);
        wsel.msk_clr = wr_en && (addr == A_MSK_CLR);
        wsel.mb_lo   = wr_en && (addr == A_MB_LO);
        wsel.mb_hi   = wr_en && (addr == A_MB_HI);
    end

    always_comb begin
        if      (addr == A_IRQ_STAT) rsel = RS_IRQ_STAT;
        else if (addr == A_IB_SET)   rsel = RS_IB;
        else if (addr == A_OB_SET)   rsel = RS_OB;
        else if (addr == A_MSK_SET)  rsel = RS_MSK;
        else if (addr == A_MB_LO)    rsel = RS_MB_LO;
        else if (addr == A_CMD)      rsel = RS_CMD;
        else                         rsel = RS_NONE;
    end
endmodule

// File: rtl/dbrb_initfsm.sv
`timescale 1ns/1ps
module dbrb_initfsm
    import dbrb_pkg::*;
#(
    parameter int unsigned INIT_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic busy
);
    localparam int unsigned CNT_W = (INIT_CYCLES > 1) ? $clog2(INIT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(INIT_CYCLES - 1);

    init_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // Next state: RESTART from any state, INIT_DONE when the count runs out
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (restart) begin
            state_d = ST_INIT;
            cnt_d   = CNT_LOAD;
        end else begin
            unique case (state_q)
                ST_INIT: begin
                    if (cnt_q == '0) state_d = ST_READY;
                    else             cnt_d   = cnt_q - 1'b1;
                end
                ST_READY: ;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_INIT;
            cnt_q   <= CNT_LOAD;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs
    always_comb begin
        busy = (state_q == ST_INIT);
    end
endmodule

// File: rtl/doorbell_regbank.sv
`timescale 1ns/1ps
module doorbell_regbank
    import dbrb_pkg::*;
#(
    parameter int unsigned ADDR_W      = 11,
    parameter int unsigned INIT_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              dev_hmb_consume,
    input  logic              dev_hmb_status_set,
    input  logic              dev_mmb_status_set,
    input  logic [15:0]       dev_cmd_id,
    input  logic [15:0]       dev_cmd_status,
    input  logic              dev_err_post,
    input  logic [7:0]        dev_err_code,
    input  logic [7:0]        dev_err_p0,
    input  logic [7:0]        dev_err_p1,
    output logic              hmb_full,
    output logic              hmb_ack_pulse,
    output logic              gen_int_pulse,
    output logic              mmb_new_pulse,
    output logic              init_busy,
    output logic [63:0]       mbox_addr,
    output logic              irq
);
    wr_sel_t    wsel;
    rd_sel_e    rsel;
    logic       ctl_rst;
    logic [1:0] ob_q, mask_q, ob_set, ob_clr, msk_set, msk_clr;
    logic       err_pend_q, err_retire;
    logic [7:0] err_code_q, err_p0_q, err_p1_q;
    logic [31:0] cmd_word_q;

    dbrb_decode #(.ADDR_W(ADDR_W)) u_dec (
        .wr_en (wr_en),
        .addr  (addr),
        .wsel  (wsel),
        .rsel  (rsel)
    );

    dbrb_initfsm #(.INIT_CYCLES(INIT_CYCLES)) u_init (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (ctl_rst),
        .busy    (init_busy)
    );

    assign ctl_rst    = wsel.ib_set & wdata[B_RST];
    assign ob_set     = {dev_mmb_status_set, dev_hmb_status_set};
    assign ob_clr     = wsel.ob_clr  ? wdata[B_HI:B_LO] : 2'b00;
    assign msk_set    = wsel.msk_set ? wdata[B_HI:B_LO] : 2'b00;
    assign msk_clr    = wsel.msk_clr ? wdata[B_HI:B_LO] : 2'b00;
    assign err_retire = wsel.ob_clr & wdata[B_HI] & wdata[B_LO];

    // Doorbell, mask and error state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hmb_full   <= 1'b0;
            ob_q       <= 2'b00;
            mask_q     <= 2'b11;
            err_pend_q <= 1'b0;
            err_code_q <= '0;
            err_p0_q   <= '0;
            err_p1_q   <= '0;
        end else begin
            mask_q <= (mask_q & ~msk_clr) | msk_set;
            if (ctl_rst) begin
                hmb_full   <= 1'b0;
                ob_q       <= 2'b00;
                err_pend_q <= 1'b0;
                err_code_q <= '0;
                err_p0_q   <= '0;
                err_p1_q   <= '0;
            end else begin
                if (wsel.ib_set && wdata[B_LO]) hmb_full <= 1'b1;
                else if (dev_hmb_consume)       hmb_full <= 1'b0;
                ob_q <= (ob_q & ~ob_clr) | ob_set;
                if (dev_err_post) begin
                    err_pend_q <= 1'b1;
                    err_code_q <= dev_err_code;
                    err_p0_q   <= dev_err_p0;
                    err_p1_q   <= dev_err_p1;
                end else if (err_retire) begin
                    err_pend_q <= 1'b0;
                    err_code_q <= '0;
                    err_p0_q   <= '0;
                    err_p1_q   <= '0;
                end
            end
        end
    end

    // Mailbox address, completion word and strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mbox_addr     <= '0;
            cmd_word_q    <= '0;
            hmb_ack_pulse <= 1'b0;
            gen_int_pulse <= 1'b0;
            mmb_new_pulse <= 1'b0;
        end else begin
            if (wsel.mb_lo) mbox_addr[31:0]  <= wdata;
            if (wsel.mb_hi) mbox_addr[63:32] <= wdata;
            if (dev_hmb_status_set) cmd_word_q <= {dev_cmd_status, dev_cmd_id};
            hmb_ack_pulse <= wsel.ib_clr & wdata[B_HI];
            gen_int_pulse <= wsel.ib_set & wdata[B_GEN];
            mmb_new_pulse <= wsel.ib_set & wdata[B_MMB];
        end
    end

    assign irq = |(ob_q & ~mask_q);

    always_comb begin
        rdata = '0;
        unique case (rsel)
            RS_IRQ_STAT: rdata[B_HI:B_LO] = ob_q & ~mask_q;
            RS_IB: begin
                rdata[B_LO] = hmb_full;
                rdata[B_HI] = init_busy;
            end
            RS_OB: begin
                rdata[B_HI:B_LO] = ob_q;
                rdata[B_ERR]     = err_pend_q;
                rdata[7:0]       = err_code_q;
            end
            RS_MSK:   rdata[B_HI:B_LO] = mask_q;
            RS_MB_LO: rdata[15:0]      = {err_p1_q, err_p0_q};
            RS_CMD:   rdata            = cmd_word_q;
            RS_NONE:  rdata            = '0;
        endcase
    end
endmodule

// File: rtl/dbrb_chk.sv
`timescale 1ns/1ps
module dbrb_chk
    import dbrb_pkg::*;
#(
    parameter int unsigned ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic              dev_hmb_status_set,
    input logic              dev_mmb_status_set,
    input logic              hmb_full,
    input logic              hmb_ack_pulse,
    input logic              init_busy,
    input logic              irq
);
    localparam logic [ADDR_W-1:0] C_IB_SET  = ADDR_W'(OFF_IB_SET);
    localparam logic [ADDR_W-1:0] C_IB_CLR  = ADDR_W'(OFF_IB_CLR);
    localparam logic [ADDR_W-1:0] C_OB_CLR  = ADDR_W'(OFF_OB_CLR);
    localparam logic [ADDR_W-1:0] C_MSK_CLR = ADDR_W'(OFF_MSK_CLR);

    logic unused_wbits;
    assign unused_wbits = ^{wdata[31:28], wdata[26], wdata[23:0]};

    // R2
    hmb_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == C_IB_SET && wdata[24] && !wdata[27]) |=> hmb_full);

    // R3
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == C_IB_CLR && wdata[25]) |=> hmb_ack_pulse);

    // R4
    ctl_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == C_IB_SET && wdata[27]) |=> (init_busy && !hmb_full && !irq));

    // R7
    irq_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == C_OB_CLR && wdata[25:24] == 2'b11
         && !dev_hmb_status_set && !dev_mmb_status_set) |=> !irq);

    // R7
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(dev_hmb_status_set || dev_mmb_status_set
                             || (wr_en && addr == C_MSK_CLR)));
endmodule

bind doorbell_regbank dbrb_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk                (clk),
    .rst_n              (rst_n),
    .wr_en              (wr_en),
    .addr               (addr),
    .wdata              (wdata),
    .dev_hmb_status_set (dev_hmb_status_set),
    .dev_mmb_status_set (dev_mmb_status_set),
    .hmb_full           (hmb_full),
    .hmb_ack_pulse      (hmb_ack_pulse),
    .init_busy          (init_busy),
    .irq                (irq)
);

// File: tb/sim_doorbell_regbank.sv
`timescale 1ns/1ps
module sim_doorbell_regbank;
    localparam int unsigned ADDR_W = 11;
    localparam int unsigned INIT_N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [10:0] addr = 11'h214;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        dev_hmb_consume = 0, dev_hmb_status_set = 0, dev_mmb_status_set = 0;
    logic [15:0] dev_cmd_id = '0, dev_cmd_status = '0;
    logic        dev_err_post = 0;
    logic [7:0]  dev_err_code = '0, dev_err_p0 = '0, dev_err_p1 = '0;
    logic        hmb_full, hmb_ack_pulse, gen_int_pulse, mmb_new_pulse, init_busy, irq;
    logic [63:0] mbox_addr;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    doorbell_regbank #(.ADDR_W(ADDR_W), .INIT_CYCLES(INIT_N)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .dev_hmb_consume(dev_hmb_consume),
        .dev_hmb_status_set(dev_hmb_status_set), .dev_mmb_status_set(dev_mmb_status_set),
        .dev_cmd_id(dev_cmd_id), .dev_cmd_status(dev_cmd_status),
        .dev_err_post(dev_err_post), .dev_err_code(dev_err_code),
        .dev_err_p0(dev_err_p0), .dev_err_p1(dev_err_p1),
        .hmb_full(hmb_full), .hmb_ack_pulse(hmb_ack_pulse),
        .gen_int_pulse(gen_int_pulse), .mmb_new_pulse(mmb_new_pulse),
        .init_busy(init_busy), .mbox_addr(mbox_addr), .irq(irq)
    );

    typedef struct packed {
        logic        rd;
        logic [3:0]  req;
        logic [10:0] a;
        logic [31:0] d;
        logic [31:0] e;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 4'd6,  11'h22C, 32'h0,        32'h03000000}, // R6 reset mask
        '{1'b1, 4'd2,  11'h214, 32'h0,        32'h00000000}, // R2 not full
        '{1'b0, 4'd2,  11'h214, 32'h01000000, 32'h0},        // R2 set full
        '{1'b1, 4'd2,  11'h214, 32'h0,        32'h01000000}, // R2
        '{1'b0, 4'd6,  11'h230, 32'h01000000, 32'h0},        // R6 unmask hw
        '{1'b1, 4'd6,  11'h22C, 32'h0,        32'h02000000}, // R6
        '{1'b1, 4'd6,  11'h230, 32'h0,        32'h00000000}, // R6 clear alias reads 0
        '{1'b0, 4'd8,  11'h510, 32'h89ABCDEF, 32'h0},        // R8
        '{1'b0, 4'd8,  11'h514, 32'h01234567, 32'h0},        // R8
        '{1'b1, 4'd10, 11'h510, 32'h0,        32'h00000000}, // R10 no params
        '{1'b0, 4'd1,  11'h62C, 32'h01000000, 32'h0},        // R1 out of window
        '{1'b1, 4'd1,  11'h22C, 32'h0,        32'h02000000}, // R1
        '{1'b0, 4'd1,  11'h22C, 32'h00000000, 32'h0},        // R1 zero write
        '{1'b1, 4'd1,  11'h22C, 32'h0,        32'h02000000}, // R1
        '{1'b0, 4'd1,  11'h22C, 32'hFCFFFFFF, 32'h0},        // R1 undefined bits
        '{1'b1, 4'd1,  11'h22C, 32'h0,        32'h02000000}, // R1
        '{1'b1, 4'd1,  11'h100, 32'h0,        32'h00000000}, // R1 hole
        '{1'b1, 4'd1,  11'h62C, 32'h0,        32'h00000000}, // R1 beyond window
        '{1'b1, 4'd7,  11'h208, 32'h0,        32'h00000000}  // R7 nothing pending
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [10:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd_chk(input string tag, input logic [10:0] a, input logic [31:0] e);
        @(negedge clk);
        addr = a;
        #1 chk(tag, 64'(rdata), 64'(e));
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (init_busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int n;
        // R4 power-on: reset state and busy window
        repeat (3) @(negedge clk);
        chk("R4 reset irq", 64'(irq), 64'd0);
        chk("R2 reset hmb_full", 64'(hmb_full), 64'd0);
        chk("R8 reset mbox_addr", mbox_addr, 64'd0);
        chk("R3 reset pulses", 64'({hmb_ack_pulse, gen_int_pulse, mmb_new_pulse}), 64'd0);
        rst_n = 1'b1;
        #0 chk("R4 init bit at 0x214", 64'(rdata), 64'h02000000);
        count_busy(n);
        chk("R4 power-on busy cycles", 64'(n), 64'(INIT_N));

        // Table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].rd) begin
                @(negedge clk);
                addr = VEC[i].a;
                #1;
                checks++;
                if (rdata !== VEC[i].e) begin
                    fails++;
                    $display("FAIL R%0d vector %0d actual=%h expected=%h",
                             VEC[i].req, i, rdata, VEC[i].e);
                end
            end else begin
                wr(VEC[i].a, VEC[i].d);
            end
        end
        chk("R8 mbox_addr", mbox_addr, 64'h01234567_89ABCDEF);

        // R9 / R5 / R7 hardware completion
        @(negedge clk);
        dev_hmb_status_set = 1; dev_cmd_id = 16'h0042; dev_cmd_status = 16'h0105;
        @(negedge clk);
        dev_hmb_status_set = 0;
        rd_chk("R9 completion word", 11'h518, 32'h01050042);
        rd_chk("R5 outbound hw", 11'h224, 32'h01000000);
        rd_chk("R7 irq status", 11'h208, 32'h01000000);
        chk("R7 irq high", 64'(irq), 64'd1);

        @(negedge clk); dev_mmb_status_set = 1;
        @(negedge clk); dev_mmb_status_set = 0;
        rd_chk("R5 outbound both", 11'h224, 32'h03000000);
        rd_chk("R7 masked mem bit", 11'h208, 32'h01000000);

        wr(11'h228, 32'h01000000);
        chk("R7 irq low after ack", 64'(irq), 64'd0);
        rd_chk("R5 hw cleared", 11'h224, 32'h02000000);
        wr(11'h228, 32'h02000000);
        rd_chk("R5 mem cleared", 11'h224, 32'h00000000);

        // R5 set beats clear
        @(negedge clk);
        wr_en = 1; addr = 11'h228; wdata = 32'h02000000; dev_mmb_status_set = 1;
        @(negedge clk);
        wr_en = 0; wdata = '0; dev_mmb_status_set = 0;
        rd_chk("R5 set wins over clear", 11'h224, 32'h02000000);

        // R2 consume and collision
        @(negedge clk); dev_hmb_consume = 1;
        @(negedge clk); dev_hmb_consume = 0;
        chk("R2 consume clears", 64'(hmb_full), 64'd0);
        @(negedge clk);
        wr_en = 1; addr = 11'h214; wdata = 32'h01000000; dev_hmb_consume = 1;
        @(negedge clk);
        wr_en = 0; wdata = '0; dev_hmb_consume = 0;
        chk("R2 set wins over consume", 64'(hmb_full), 64'd1);

        // R3 strobes
        wr(11'h214, 32'h14000000);
        chk("R3 gen+mmb strobes", 64'({gen_int_pulse, mmb_new_pulse, hmb_ack_pulse}), 64'b110);
        @(negedge clk);
        chk("R3 strobes one cycle", 64'({gen_int_pulse, mmb_new_pulse}), 64'd0);
        wr(11'h218, 32'h02000000);
        chk("R3 ack strobe", 64'(hmb_ack_pulse), 64'd1);

        // R10 error post and retire
        @(negedge clk);
        dev_err_post = 1; dev_err_code = 8'h5A; dev_err_p0 = 8'h11; dev_err_p1 = 8'h22;
        @(negedge clk);
        dev_err_post = 0;
        rd_chk("R10 error word", 11'h224, 32'h2200005A);
        rd_chk("R10 params", 11'h510, 32'h00002211);
        wr(11'h228, 32'h01000000);
        rd_chk("R10 single bit keeps error", 11'h224, 32'h2200005A);
        wr(11'h228, 32'h03000000);
        rd_chk("R10 retired", 11'h224, 32'h00000000);
        rd_chk("R10 params cleared", 11'h510, 32'h00000000);

        // R4 controller reset
        wr(11'h214, 32'h01000000);
        @(negedge clk); dev_hmb_status_set = 1; dev_err_post = 1;
        @(negedge clk); dev_hmb_status_set = 0; dev_err_post = 0;
        chk("R4 irq before reset", 64'(irq), 64'd1);
        wr(11'h214, 32'h08000000);
        chk("R4 full cleared", 64'(hmb_full), 64'd0);
        chk("R4 irq cleared", 64'(irq), 64'd0);
        count_busy(n);
        chk("R4 busy cycles after doorbell", 64'(n), 64'(INIT_N));
        rd_chk("R4 inbound after init", 11'h214, 32'h00000000);
        rd_chk("R4 outbound and error cleared", 11'h224, 32'h00000000);
        rd_chk("R4 mask kept", 11'h22C, 32'h02000000);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule